// File: doc/BRIEF.md
# DLL Phase Select Sequencer

This block moves the sampling clock output of a delay-locked line to a new phase position between 0 and 15. A single-cycle start request carries a 4-bit phase number. The block then runs a fixed handshake on the line's control bits. It parks the line on an external clock-data-recovery source with its output gated off, and waits until the line reports the output as off. It then loads the Gray-coded phase into the select field and turns the output back on. After the line reports the output as on, control returns to the internal recovery loop.

The two readback waits are timed in microsecond ticks, which a parameterised divider makes from the system clock. Each wait gives up after a bounded number of ticks. The block reports its result as a one-cycle done or timeout pulse. The delay line itself sits outside the block. Only its control inputs and its clock-output-enable readback pass through the ports.

Top module: `dll_phase_seq`

## Requirements
- R1: On completion, sel_o holds the reflected Gray code of the requested phase. For phase 0..15 the codes are 0,1,3,2,6,7,5,4,12,13,15,14,10,11,9,8 in that order.
- R2: The clock edge that accepts a start sets cdr_en_o=0, ck_out_en_o=0, cdr_ext_en_o=1 and dll_en_o=1, and raises busy_o.
- R3: sel_o keeps its old value until ck_out_fb_i has been sampled as 0 on a tick. If the readback never drops, sel_o is never written.
- R4: sel_o changes only while ck_out_en_o is 0. After the load, ck_out_en_o goes to 1 and the block waits for ck_out_fb_i = 1.
- R5: After ck_out_fb_i is sampled as 1, the block sets cdr_en_o=1 and cdr_ext_en_o=0 in the same edge that raises done_o. dll_en_o and ck_out_en_o stay 1.
- R6: The readback is sampled once per tick of TICK_DIV clock cycles, and each wait allows at most POLL_LIMIT samples. A readback stuck at 1 gives timeout_o exactly POLL_LIMIT*TICK_DIV clock edges after the accepting edge.
- R7: On timeout, every control output keeps the value it had when the sequence aborted.
- R8: A start request while busy_o is 1 is ignored: the phase applied at completion is the one accepted first.
- R9: done_o and timeout_o are single-cycle pulses, never high together, and busy_o is 0 whenever either is high.
- R10: After reset, all control outputs, busy_o, done_o and timeout_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, one cycle |
| phase_i | input | PHASE_W | Requested phase in binary |
| ck_out_fb_i | input | 1 | Clock-output-enable readback from the delay line |
| cdr_en_o | output | 1 | Internal clock-data-recovery enable |
| cdr_ext_en_o | output | 1 | External recovery source enable |
| dll_en_o | output | 1 | Delay line enable |
| ck_out_en_o | output | 1 | Clock output enable |
| sel_o | output | PHASE_W | Gray-coded phase select field |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Successful completion pulse |
| timeout_o | output | 1 | Readback wait expired pulse |

## Verification
The step-one control values and busy_o are due on the clock edge that samples start_i, and the bench reads them one time unit after that edge. Start also restarts the tick divider, so with a stuck readback timeout_o is due exactly POLL_LIMIT*TICK_DIV edges later. The bench counts edges and confirms the pulse is low one edge before and high on that edge. For completions with a random readback lag, the finish time depends on how the lag falls against the ticks. The bench therefore waits in a bounded loop for the pulse and checks the outputs and the pulse width on that cycle and the next.

// File: rtl/dps_pkg.sv
package dps_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT_OFF,
    S_LOAD,
    S_SET_ON,
    S_WAIT_ON
  } dps_state_e;

  typedef struct packed {
    logic cdr_en;
    logic cdr_ext_en;
    logic dll_en;
    logic ck_out_en;
  } dps_ctl_t;
endpackage

// File: rtl/dps_tick_gen.sv
module dps_tick_gen #(
  parameter int unsigned DIV = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/dps_gray_enc.sv
module dps_gray_enc #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] bin_i,
  output logic [W-1:0] gray_o
);
  assign gray_o[W-1] = bin_i[W-1];
  for (genvar i = 0; i < W - 1; i++) begin : g_bit
    assign gray_o[i] = bin_i[i] ^ bin_i[i+1];
  end
endmodule

// File: rtl/dps_poll_cnt.sv
module dps_poll_cnt #(
  parameter int unsigned LIMIT = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic last_o
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= '0;
    else if (tick_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  // high while the current sample is the final one allowed
  assign last_o = (cnt_q == LAST);
endmodule

// File: rtl/dll_phase_seq.sv
module dll_phase_seq
  import dps_pkg::*;
#(
  parameter int unsigned PHASE_W    = 4,
  parameter int unsigned TICK_DIV   = 100,
  parameter int unsigned POLL_LIMIT = 50
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic               ck_out_fb_i,
  output logic               cdr_en_o,
  output logic               cdr_ext_en_o,
  output logic               dll_en_o,
  output logic               ck_out_en_o,
  output logic [PHASE_W-1:0] sel_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               timeout_o
);
  dps_state_e         state_q;
  dps_ctl_t           ctl_q;
  logic [PHASE_W-1:0] sel_q, pend_q, gray;
  logic               done_q, to_q;
  logic               tick, last, accept, poll_clr;

  assign accept   = (state_q == S_IDLE) && start_i;
  assign poll_clr = (state_q == S_IDLE) || (state_q == S_SET_ON);

  dps_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i, .rst_ni, .clr_i(accept), .tick_o(tick)
  );

  dps_poll_cnt #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk_i, .rst_ni, .clr_i(poll_clr), .tick_i(tick), .last_o(last)
  );

  dps_gray_enc #(.W(PHASE_W)) u_gray (
    .bin_i(phase_i), .gray_o(gray)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ctl_q   <= '0;
      sel_q   <= '0;
      pend_q  <= '0;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      to_q   <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          pend_q           <= gray;
          ctl_q.cdr_en     <= 1'b0;
          ctl_q.ck_out_en  <= 1'b0;
          ctl_q.cdr_ext_en <= 1'b1;
          ctl_q.dll_en     <= 1'b1;
          state_q          <= S_WAIT_OFF;
        end
        S_WAIT_OFF: if (tick) begin
          if (!ck_out_fb_i) state_q <= S_LOAD;
          else if (last) begin
            to_q    <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        S_LOAD: begin
          sel_q   <= pend_q;
          state_q <= S_SET_ON;
        end
        S_SET_ON: begin
          ctl_q.ck_out_en <= 1'b1;
          state_q         <= S_WAIT_ON;
        end
        S_WAIT_ON: if (tick) begin
          if (ck_out_fb_i) begin
            ctl_q.cdr_en     <= 1'b1;
            ctl_q.cdr_ext_en <= 1'b0;
            done_q           <= 1'b1;
            state_q          <= S_IDLE;
          end else if (last) begin
            to_q    <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cdr_en_o     = ctl_q.cdr_en;
  assign cdr_ext_en_o = ctl_q.cdr_ext_en;
  assign dll_en_o     = ctl_q.dll_en;
  assign ck_out_en_o  = ctl_q.ck_out_en;
  assign sel_o        = sel_q;
  assign busy_o       = (state_q != S_IDLE);
  assign done_o       = done_q;
  assign timeout_o    = to_q;
endmodule

// File: rtl/dps_checker.sv
module dps_checker #(
  parameter int unsigned PHASE_W = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cdr_en_o,
  input logic               cdr_ext_en_o,
  input logic               dll_en_o,
  input logic               ck_out_en_o,
  input logic [PHASE_W-1:0] sel_o,
  input logic               busy_o,
  input logic               done_o,
  input logic               timeout_o
);
  a_r2_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (!cdr_en_o && !ck_out_en_o && cdr_ext_en_o && dll_en_o));

  a_r4_sel_while_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sel_o) |-> !ck_out_en_o);

  a_r5_final_ctl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cdr_en_o && !cdr_ext_en_o && dll_en_o && ck_out_en_o));

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_timeout_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);

  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || timeout_o) |-> (!busy_o && !(done_o && timeout_o)));

  a_r7_hold_after_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> (busy_o || ($stable(sel_o) && $stable(ck_out_en_o) && $stable(cdr_en_o))));
endmodule

bind dll_phase_seq dps_checker #(.PHASE_W(PHASE_W)) u_dps_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cdr_en_o(cdr_en_o), .cdr_ext_en_o(cdr_ext_en_o),
  .dll_en_o(dll_en_o), .ck_out_en_o(ck_out_en_o), .sel_o(sel_o), .busy_o(busy_o),
  .done_o(done_o), .timeout_o(timeout_o)
);

// File: tb/dll_phase_seq_tb.sv
`timescale 1ns/1ps
module dll_phase_seq_tb;
  localparam int DIV   = 4;
  localparam int LIMIT = 50;

  logic       clk = 0, rst_n = 0, start = 0, fb;
  logic [3:0] phase = 0, sel;
  logic       cdr_en, cdr_ext, dll_en, ck_en, busy, done, tout;

  int n_tests = 0, n_fail = 0, cyc = 0;
  int lag = 0, lc = 0, fb_mode = 0;  // 0 follow, 1 stuck high, 2 stuck low

  always #5 clk = ~clk;

  dll_phase_seq #(.PHASE_W(4), .TICK_DIV(DIV), .POLL_LIMIT(LIMIT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .phase_i(phase), .ck_out_fb_i(fb),
    .cdr_en_o(cdr_en), .cdr_ext_en_o(cdr_ext), .dll_en_o(dll_en), .ck_out_en_o(ck_en),
    .sel_o(sel), .busy_o(busy), .done_o(done), .timeout_o(tout)
  );

  // behavioural readback: follows ck_en after lag cycles
  always @(posedge clk) begin
    if (!rst_n) begin fb <= 1'b0; lc <= 0; end
    else if (fb_mode == 1) fb <= 1'b1;
    else if (fb_mode == 2) fb <= 1'b0;
    else if (fb != ck_en) begin
      if (lc >= lag) begin fb <= ck_en; lc <= 0; end
      else lc <= lc + 1;
    end else lc <= 0;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_tests = n_tests + 1; n_fail = n_fail + 1;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [3:0] gray_ref(input logic [3:0] p);
    case (p)
      4'd0: return 4'h0;  4'd1: return 4'h1;  4'd2: return 4'h3;  4'd3: return 4'h2;
      4'd4: return 4'h6;  4'd5: return 4'h7;  4'd6: return 4'h5;  4'd7: return 4'h4;
      4'd8: return 4'hc;  4'd9: return 4'hd;  4'd10: return 4'hf; 4'd11: return 4'he;
      4'd12: return 4'ha; 4'd13: return 4'hb; 4'd14: return 4'h9; default: return 4'h8;
    endcase
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_tests = n_tests + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // start at a negedge, return 1ns after accepting edge
  task automatic kick(input logic [3:0] p);
    @(negedge clk); phase = p; start = 1;
    @(posedge clk); #1; start = 0;
  endtask

  // wait for done/timeout; returns 1 on done, 0 on timeout, -1 on none
  task automatic wait_end(output int res);
    res = -1;
    for (int i = 0; i < 2 * LIMIT * DIV + 40; i++) begin
      @(posedge clk); #1;
      if (done || tout) begin
        res = done ? 1 : 0;
        check(!busy && !(done && tout), "R9 exclusive", {busy, done, tout}, 3'b010);
        @(posedge clk); #1;
        check(!done && !tout, "R9 single-cycle pulse", {done, tout}, 0);
        break;
      end
    end
  endtask

  task automatic run_ok(input logic [3:0] p, input int l);
    int res;
    fb_mode = 0; lag = l;
    kick(p);
    check(!cdr_en && !ck_en && cdr_ext && dll_en && busy, "R2 step one",
          {cdr_en, cdr_ext, dll_en, ck_en, busy}, 5'b01101);
    wait_end(res);
    check(res == 1, "R4 completion after readback 1", res, 1);
    check(sel == gray_ref(p), "R1 gray select", sel, gray_ref(p));
    check(cdr_en && !cdr_ext && dll_en && ck_en, "R5 final control",
          {cdr_en, cdr_ext, dll_en, ck_en}, 4'b1011);
  endtask

  initial begin
    int r, res;
    logic [3:0] old_sel;
    r = $urandom(32'h5eed);
    repeat (3) @(posedge clk);
    #1;
    check({cdr_en, cdr_ext, dll_en, ck_en, sel, busy, done, tout} == 0, "R10 reset state",
          {cdr_en, cdr_ext, dll_en, ck_en, sel, busy, done, tout}, 0);
    @(negedge clk); rst_n = 1;

    // R1 every phase, directed
    for (int p = 0; p < 16; p++) run_ok(4'(p), p % 3);

    // random phases and lags
    for (int k = 0; k < 12; k++) run_ok(4'($urandom % 16), int'($urandom % (8 * DIV)));

    // R8 start while busy is ignored
    fb_mode = 0; lag = 2 * DIV;
    kick(4'd6);
    @(negedge clk); phase = 4'd11; start = 1;
    @(negedge clk); start = 0;
    wait_end(res);
    check(res == 1 && sel == gray_ref(4'd6), "R8 busy start ignored", sel, gray_ref(4'd6));

    // R3/R6/R7 readback stuck high: exact timeout edge, select untouched
    old_sel = sel;
    fb_mode = 1;
    repeat (2) @(posedge clk);
    kick(4'd3);
    for (int m = 1; m <= LIMIT * DIV; m++) begin
      @(posedge clk); #1;
      if (m == LIMIT * DIV - 1) check(!tout, "R6 no timeout one edge early", tout, 0);
      if (m < LIMIT * DIV) begin
        if (sel != old_sel) check(0, "R3 select held while readback high", sel, old_sel);
      end
    end
    check(tout && !done, "R6 timeout at POLL_LIMIT*TICK_DIV edges", tout, 1);
    check(sel == old_sel, "R3 select never written", sel, old_sel);
    check(!cdr_en && cdr_ext && dll_en && !ck_en, "R7 outputs held on timeout (off wait)",
          {cdr_en, cdr_ext, dll_en, ck_en}, 4'b0110);
    repeat (5) @(posedge clk); #1;
    check(!busy && sel == old_sel && !ck_en, "R7 held after abort", sel, old_sel);

    // R7 readback stuck low: timeout in the on wait
    fb_mode = 2;
    kick(4'd9);
    wait_end(res);
    check(res == 0, "R4 waits for readback 1 then times out", res, 0);
    check(sel == gray_ref(4'd9) && ck_en && !cdr_en && cdr_ext && dll_en,
          "R7 outputs held on timeout (on wait)", {cdr_en, cdr_ext, dll_en, ck_en, sel},
          {4'b0111, gray_ref(4'd9)});

    // recovery after timeout
    run_ok(4'd15, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule